// File: doc/BRIEF.md
# Two-Level Budget-Server Task Scheduler

This block picks, every clock cycle, one real-time I/O task to run. Tasks are grouped under execution-time servers. Each server has a programmable importance priority, an execution budget and a replenishment period. A global stage tracks each server's budget with two count-down timers and selects the most important server that still has budget and holds work. Each server's local stage keeps a compact buffer of its tasks and offers its most urgent one. The global choice selects which local answer is issued, so a scheduled server ID and task ID come out in the same cycle.

A server that runs long only uses up its own budget. Once the budget is spent, the server drops out of arbitration until its period timer expires and refills it, and less important servers get the cycles. Software sets up servers through an address/data configuration port. It adds tasks with an insert port and takes them away with a remove port.

Top module: `ets_sched_top`

## Requirements
- R1: After reset `sch_valid` is 0, both ID outputs are 0, and every server has priority, budget and period equal to 0 and no tasks.
- R2: A server takes part in arbitration only while its remaining budget is nonzero and it holds at least one task. A server with tasks but zero budget, or with budget but no tasks, is never scheduled.
- R3: Among eligible servers, the one with the larger 8-bit priority is scheduled. On equal priority the lower server index wins.
- R4: Within the scheduled server, the task with the larger 8-bit priority is issued. On equal priority the task in the lower buffer slot wins. Slots fill in insertion order.
- R5: Remaining budget drops by one on every clock edge at which that server is scheduled and its period timer is nonzero. At zero the server leaves arbitration.
- R6: The period timer drops by one every edge. On an edge where it is 0, the budget reloads to the configured budget and the timer reloads to the configured period. A configured period of 0 therefore refills the budget every cycle.
- R7: An insert places the task in the first free slot of the addressed server. An insert into a full buffer (8 tasks) is dropped.
- R8: A remove clears the lowest slot whose valid task ID matches `rm_tid`, and every later task moves down one slot, keeping their order. A remove with no match changes nothing.
- R9: When an insert and a remove address the same server in the same cycle, the remove is applied first and the insert then uses the first free slot after it. This makes an insert into a full buffer succeed when a matching remove frees a slot.
- R10: A configuration write uses `cfg_addr[3:2]` as the server index and `cfg_addr[1:0]` as the field. Field 0 sets the priority from `cfg_wdata[7:0]`. Field 1 sets the budget and loads the remaining budget at once. Field 2 sets the period and loads the period timer at once. Field 3 writes have no effect.
- R11: While no server is eligible, `sch_valid` is 0 and `sch_srv` and `sch_tid` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Server index (bits 3:2) and field select (bits 1:0) |
| cfg_wdata | input | 16 | Configuration write data |
| ins_en | input | 1 | Insert a task |
| ins_srv | input | 2 | Server receiving the inserted task |
| ins_tid | input | 8 | Inserted task ID |
| ins_prio | input | 8 | Inserted task priority |
| rm_en | input | 1 | Remove a task |
| rm_srv | input | 2 | Server the task is removed from |
| rm_tid | input | 8 | Task ID to remove |
| sch_valid | output | 1 | A task is scheduled this cycle |
| sch_srv | output | 2 | Scheduled server ID |
| sch_tid | output | 8 | Scheduled task ID |

## Verification
Two pairs of operations can land on the same edge. The first is an insert and a remove aimed at one task buffer. The bench drives both in one cycle, once on a partly filled buffer and once on a full one. It judges the result by which task is issued afterwards: a newly inserted top-priority task must win only when the remove made room. The second is budget burn and period reload. The bench programs a short period and a small budget, then counts edges. The server must drop out exactly when its budget hits zero and come back on the edge where the period timer wraps.

// File: rtl/ets_pkg.sv
package ets_pkg;
  parameter int TID_W  = 8;
  parameter int PRIO_W = 8;

  typedef enum logic [1:0] {
    FLD_PRIO   = 2'd0,
    FLD_BUDGET = 2'd1,
    FLD_PERIOD = 2'd2,
    FLD_RSVD   = 2'd3
  } cfg_fld_e;

  typedef struct packed {
    logic              vld;
    logic [TID_W-1:0]  tid;
    logic [PRIO_W-1:0] prio;
  } slot_t;
endpackage

// File: rtl/ets_task_buf.sv
module ets_task_buf
  import ets_pkg::*;
#(
  parameter int N_SLOT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_en,
  input  logic [TID_W-1:0]  ins_tid,
  input  logic [PRIO_W-1:0] ins_prio,
  input  logic              rm_en,
  input  logic [TID_W-1:0]  rm_tid,
  output logic              any_vld,
  output logic [TID_W-1:0]  best_tid
);
  localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

  slot_t slot_q [N_SLOT];
  slot_t slot_d [N_SLOT];
  slot_t ext    [N_SLOT+1];
  slot_t shifted[N_SLOT];

  logic              hit;
  logic [SLOT_W-1:0] hit_idx;
  logic              has_free;
  logic [SLOT_W-1:0] free_idx;
  logic              upd_en;
  logic [PRIO_W-1:0] best_prio;
  logic [N_SLOT-1:0] vld_vec;

  // remove first, then insert into the first hole left
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int j = 0; j < N_SLOT; j++) begin
      if (!hit && slot_q[j].vld && (slot_q[j].tid == rm_tid)) begin
        hit     = 1'b1;
        hit_idx = SLOT_W'(j);
      end
    end
    for (int j = 0; j < N_SLOT; j++) ext[j] = slot_q[j];
    ext[N_SLOT] = '0;
    for (int j = 0; j < N_SLOT; j++) begin
      if (rm_en && hit && (SLOT_W'(j) >= hit_idx)) shifted[j] = ext[j+1];
      else                                          shifted[j] = ext[j];
    end
    has_free = 1'b0;
    free_idx = '0;
    for (int j = 0; j < N_SLOT; j++) begin
      if (!has_free && !shifted[j].vld) begin
        has_free = 1'b1;
        free_idx = SLOT_W'(j);
      end
    end
    for (int j = 0; j < N_SLOT; j++) begin
      slot_d[j] = shifted[j];
      if (ins_en && has_free && (SLOT_W'(j) == free_idx)) begin
        slot_d[j].vld  = 1'b1;
        slot_d[j].tid  = ins_tid;
        slot_d[j].prio = ins_prio;
      end
    end
    upd_en = ins_en | rm_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N_SLOT; j++) slot_q[j] <= '0;
    end else if (upd_en) begin
      for (int j = 0; j < N_SLOT; j++) slot_q[j] <= slot_d[j];
    end
  end

  // parallel compare, strict greater keeps the lower slot on ties
  always_comb begin
    any_vld   = 1'b0;
    best_tid  = '0;
    best_prio = '0;
    for (int j = 0; j < N_SLOT; j++) begin
      if (slot_q[j].vld && (!any_vld || (slot_q[j].prio > best_prio))) begin
        any_vld   = 1'b1;
        best_tid  = slot_q[j].tid;
        best_prio = slot_q[j].prio;
      end
    end
  end

  always_comb begin
    for (int j = 0; j < N_SLOT; j++) vld_vec[j] = slot_q[j].vld;
  end

  // R8: valid entries stay packed toward slot 0
  a_r8_packed: assert property (@(posedge clk) disable iff (!rst_n)
    ((vld_vec + N_SLOT'(1)) & vld_vec) == '0);

  // R7: an insert alone into a non-full buffer adds exactly one entry
  a_r7_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !rm_en && !(&vld_vec)) |=> ($countones(vld_vec) == $countones($past(vld_vec)) + 1));
endmodule

// File: rtl/ets_srv_ctrl.sv
module ets_srv_ctrl
  import ets_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prio_we,
  input  logic              bud_we,
  input  logic              per_we,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              sched,
  input  logic              has_task,
  output logic [PRIO_W-1:0] prio,
  output logic              eligible
);
  logic [PRIO_W-1:0] prio_q,    prio_d;
  logic [CNT_W-1:0]  bud_cfg_q, bud_cfg_d;
  logic [CNT_W-1:0]  per_cfg_q, per_cfg_d;
  logic [CNT_W-1:0]  bud_q,     bud_d;
  logic [CNT_W-1:0]  per_q,     per_d;
  logic              wrap;

  always_comb begin
    prio_d    = prio_we ? wdata[PRIO_W-1:0] : prio_q;
    bud_cfg_d = bud_we  ? wdata : bud_cfg_q;
    per_cfg_d = per_we  ? wdata : per_cfg_q;
    wrap      = (per_q == '0);
    if (wrap) begin
      bud_d = bud_cfg_q;
      per_d = per_cfg_q;
    end else begin
      bud_d = (sched && (bud_q != '0)) ? bud_q - CNT_W'(1) : bud_q;
      per_d = per_q - CNT_W'(1);
    end
    if (bud_we) bud_d = wdata;
    if (per_we) per_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q    <= '0;
      bud_cfg_q <= '0;
      per_cfg_q <= '0;
      bud_q     <= '0;
      per_q     <= '0;
    end else begin
      prio_q    <= prio_d;
      bud_cfg_q <= bud_cfg_d;
      per_cfg_q <= per_cfg_d;
      bud_q     <= bud_d;
      per_q     <= per_d;
    end
  end

  assign prio     = prio_q;
  assign eligible = (bud_q != '0) && has_task;

  // R2: the arbiter only picks a server with budget and work
  a_r2_sched_ok: assert property (@(posedge clk) disable iff (!rst_n)
    sched |-> ((bud_q != '0) && has_task));

  // R5: one unit burned per scheduled cycle outside a wrap or write
  a_r5_burn: assert property (@(posedge clk) disable iff (!rst_n)
    (sched && (per_q != '0) && !bud_we) |=> (bud_q == $past(bud_q) - CNT_W'(1)));

  // R6: timer at zero refills the budget
  a_r6_refill: assert property (@(posedge clk) disable iff (!rst_n)
    ((per_q == '0) && !bud_we && !per_we) |=> ((bud_q == $past(bud_cfg_q)) && (per_q == $past(per_cfg_q))));
endmodule

// File: rtl/ets_global_arb.sv
module ets_global_arb
  import ets_pkg::*;
#(
  parameter int N_SRV = 4,
  localparam int SRV_W = (N_SRV > 1) ? $clog2(N_SRV) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_SRV-1:0]              elig,
  input  logic [N_SRV-1:0][PRIO_W-1:0]  prio,
  output logic                          win_vld,
  output logic [SRV_W-1:0]              win_idx
);
  logic [PRIO_W-1:0] win_prio;

  always_comb begin
    win_vld  = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < N_SRV; i++) begin
      if (elig[i] && (!win_vld || (prio[i] > win_prio))) begin
        win_vld  = 1'b1;
        win_idx  = SRV_W'(i);
        win_prio = prio[i];
      end
    end
  end

  // R3: no eligible server beats the winner, and lower indices do not tie it
  always_ff @(posedge clk) begin
    if (rst_n && win_vld) begin
      for (int i = 0; i < N_SRV; i++) begin
        if (elig[i]) begin
          a_r3_best: assert (prio[i] <= prio[win_idx]);
          if (SRV_W'(i) < win_idx) begin
            a_r3_low_index: assert (prio[i] < prio[win_idx]);
          end
        end
      end
    end
  end

  // R2: nothing eligible means nothing wins
  a_r2_none: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> !win_vld);
endmodule

// File: rtl/ets_sched_top.sv
module ets_sched_top
  import ets_pkg::*;
#(
  parameter int N_SRV  = 4,
  parameter int N_SLOT = 8,
  parameter int CNT_W  = 16,
  localparam int SRV_W = (N_SRV > 1) ? $clog2(N_SRV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SRV_W+1:0]   cfg_addr,
  input  logic [CNT_W-1:0]   cfg_wdata,
  input  logic               ins_en,
  input  logic [SRV_W-1:0]   ins_srv,
  input  logic [TID_W-1:0]   ins_tid,
  input  logic [PRIO_W-1:0]  ins_prio,
  input  logic               rm_en,
  input  logic [SRV_W-1:0]   rm_srv,
  input  logic [TID_W-1:0]   rm_tid,
  output logic               sch_valid,
  output logic [SRV_W-1:0]   sch_srv,
  output logic [TID_W-1:0]   sch_tid
);
  logic [SRV_W-1:0]              cfg_srv;
  cfg_fld_e                      cfg_fld;
  logic [N_SRV-1:0]              elig;
  logic [N_SRV-1:0]              has_task;
  logic [N_SRV-1:0][PRIO_W-1:0]  srv_prio;
  logic [N_SRV-1:0][TID_W-1:0]   loc_tid;
  logic                          win_vld;
  logic [SRV_W-1:0]              win_idx;

  assign cfg_srv = cfg_addr[SRV_W+1:2];
  assign cfg_fld = cfg_fld_e'(cfg_addr[1:0]);

  for (genvar g = 0; g < N_SRV; g++) begin : g_srv
    logic hit_cfg;
    assign hit_cfg = cfg_we && (cfg_srv == SRV_W'(g));

    ets_srv_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .prio_we  (hit_cfg && (cfg_fld == FLD_PRIO)),
      .bud_we   (hit_cfg && (cfg_fld == FLD_BUDGET)),
      .per_we   (hit_cfg && (cfg_fld == FLD_PERIOD)),
      .wdata    (cfg_wdata),
      .sched    (win_vld && (win_idx == SRV_W'(g))),
      .has_task (has_task[g]),
      .prio     (srv_prio[g]),
      .eligible (elig[g])
    );

    ets_task_buf #(.N_SLOT(N_SLOT)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .ins_en   (ins_en && (ins_srv == SRV_W'(g))),
      .ins_tid  (ins_tid),
      .ins_prio (ins_prio),
      .rm_en    (rm_en && (rm_srv == SRV_W'(g))),
      .rm_tid   (rm_tid),
      .any_vld  (has_task[g]),
      .best_tid (loc_tid[g])
    );
  end

  ets_global_arb #(.N_SRV(N_SRV)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig    (elig),
    .prio    (srv_prio),
    .win_vld (win_vld),
    .win_idx (win_idx)
  );

  assign sch_valid = win_vld;
  assign sch_srv   = win_vld ? win_idx : '0;
  assign sch_tid   = win_vld ? loc_tid[win_idx] : '0;

  // R11: idle outputs read zero
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sch_valid |-> ((sch_srv == '0) && (sch_tid == '0)));

  // R2: an issued server always holds a task
  a_r2_has_work: assert property (@(posedge clk) disable iff (!rst_n)
    sch_valid |-> has_task[sch_srv]);
endmodule

// File: tb/sim_ets_sched_top.sv
module sim_ets_sched_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        ins_en;
  logic [1:0]  ins_srv;
  logic [7:0]  ins_tid;
  logic [7:0]  ins_prio;
  logic        rm_en;
  logic [1:0]  rm_srv;
  logic [7:0]  rm_tid;
  logic        sch_valid;
  logic [1:0]  sch_srv;
  logic [7:0]  sch_tid;

  int total = 0;
  int bad   = 0;

  ets_sched_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ins_en(ins_en), .ins_srv(ins_srv), .ins_tid(ins_tid), .ins_prio(ins_prio),
    .rm_en(rm_en), .rm_srv(rm_srv), .rm_tid(rm_tid),
    .sch_valid(sch_valid), .sch_srv(sch_srv), .sch_tid(sch_tid)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    ins_en = 0; ins_srv = '0; ins_tid = '0; ins_prio = '0;
    rm_en = 0; rm_srv = '0; rm_tid = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic cfg(input logic [1:0] s, input logic [1:0] f, input logic [15:0] d);
    cfg_we = 1; cfg_addr = {s, f}; cfg_wdata = d;
    tick();
    idle_inputs();
  endtask

  task automatic ins(input logic [1:0] s, input logic [7:0] t, input logic [7:0] p);
    ins_en = 1; ins_srv = s; ins_tid = t; ins_prio = p;
    tick();
    idle_inputs();
  endtask

  task automatic rm(input logic [1:0] s, input logic [7:0] t);
    rm_en = 1; rm_srv = s; rm_tid = t;
    tick();
    idle_inputs();
  endtask

  task automatic ins_rm(input logic [1:0] s, input logic [7:0] ti, input logic [7:0] p,
                        input logic [7:0] tr);
    ins_en = 1; ins_srv = s; ins_tid = ti; ins_prio = p;
    rm_en = 1; rm_srv = s; rm_tid = tr;
    tick();
    idle_inputs();
  endtask

  task automatic chk(input string req, input logic ev, input logic [1:0] es, input logic [7:0] et);
    total++;
    if (sch_valid !== ev || sch_srv !== es || sch_tid !== et) begin
      bad++;
      $display("FAIL %s: actual v=%0b srv=%0d tid=%0d expected v=%0b srv=%0d tid=%0d",
               req, sch_valid, sch_srv, sch_tid, ev, es, et);
    end
  endtask

  // field codes: 0 priority, 1 budget, 2 period, 3 reserved
  task automatic test_reset();
    do_reset();
    chk("R1 reset idle", 0, 0, 0);
    ins(0, 8'd3, 8'd1);
    chk("R2 task but zero budget", 0, 0, 0);
    do_reset();
    cfg(1, 2'd1, 16'd5);
    chk("R2 budget but no task / R11 zero ids", 0, 0, 0);
  endtask

  task automatic test_server_prio();
    do_reset();
    for (int s = 0; s < 3; s++) begin
      cfg(2'(s), 2'd1, 16'd9);
      ins(2'(s), 8'(40 + s), 8'd1);
    end
    cfg(0, 2'd0, 16'd5);
    cfg(1, 2'd0, 16'd9);
    cfg(2, 2'd0, 16'd9);
    chk("R3 higher prio, tie to lower index", 1, 1, 8'd41);
    cfg(1, 2'd3, 16'hFFFF);
    chk("R10 reserved field ignored", 1, 1, 8'd41);
    cfg(1, 2'd0, 16'd3);
    chk("R3 reprogrammed prio", 1, 2, 8'd42);
  endtask

  task automatic test_task_prio();
    do_reset();
    cfg(0, 2'd1, 16'd50);
    ins(0, 8'd10, 8'd4);
    ins(0, 8'd11, 8'd7);
    ins(0, 8'd12, 8'd7);
    chk("R4 highest task, tie to lower slot", 1, 0, 8'd11);
    rm(0, 8'd11);
    chk("R8 remove shifts later entries", 1, 0, 8'd12);
    ins(0, 8'd13, 8'd7);
    chk("R7 append after shift keeps order", 1, 0, 8'd12);
    rm(0, 8'd99);
    chk("R8 remove without match ignored", 1, 0, 8'd12);
    ins_rm(0, 8'd14, 8'd7, 8'd12);
    chk("R9 same-cycle remove then insert", 1, 0, 8'd13);
  endtask

  task automatic test_full();
    do_reset();
    cfg(3, 2'd1, 16'd50);
    for (int k = 0; k < 8; k++) ins(3, 8'(20 + k), 8'd1);
    chk("R7 full buffer oldest wins", 1, 3, 8'd20);
    ins(3, 8'd30, 8'd200);
    chk("R7 insert into full dropped", 1, 3, 8'd20);
    rm(3, 8'd20);
    chk("R8 remove slot 0", 1, 3, 8'd21);
    ins(3, 8'd31, 8'd1);
    ins_rm(3, 8'd32, 8'd250, 8'd21);
    chk("R9 full buffer insert with remove accepted", 1, 3, 8'd32);
  endtask

  task automatic test_budget();
    do_reset();
    cfg(0, 2'd2, 16'd1000);
    cfg(0, 2'd1, 16'd3);
    ins(0, 8'd5, 8'd1);
    chk("R5 budget 3 first cycle", 1, 0, 8'd5);
    tick();
    tick();
    chk("R5 budget 1 still running", 1, 0, 8'd5);
    tick();
    chk("R5 budget spent, idle", 0, 0, 0);
  endtask

  task automatic test_period();
    do_reset();
    ins(1, 8'd7, 8'd2);
    cfg(1, 2'd2, 16'd5);
    cfg(1, 2'd1, 16'd2);
    chk("R10 budget write loads counter", 1, 1, 8'd7);
    tick();
    tick();
    chk("R5 budget out before wrap", 0, 0, 0);
    tick();
    tick();
    chk("R6 timer at zero, not yet refilled", 0, 0, 0);
    tick();
    chk("R6 refill on wrap edge", 1, 1, 8'd7);
  endtask

  task automatic test_contention();
    do_reset();
    cfg(0, 2'd2, 16'd1000);
    cfg(0, 2'd1, 16'd2);
    cfg(0, 2'd0, 16'd9);
    cfg(1, 2'd1, 16'd4);
    cfg(1, 2'd0, 16'd1);
    ins(1, 8'd60, 8'd1);
    ins(0, 8'd50, 8'd1);
    chk("R3 important server first", 1, 0, 8'd50);
    tick();
    tick();
    chk("R5 overrun server yields to lower", 1, 1, 8'd60);
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    test_reset();
    test_server_prio();
    test_task_prio();
    test_full();
    test_budget();
    test_period();
    test_contention();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule